// File: doc/BRIEF.md
# Key-Gated Read/Write Bank Mapper

This block turns two byte-wide host registers into two independent base offsets into video memory. One base serves host reads and the other serves host writes. Both are built in steps of 64 KiB. The bank select byte supplies a 4-bit bank number for each direction. The bank extension byte supplies the top bit of each base, so the bases span a 2 MiB space.

Two conditions gate bank updates: an unlock key must be asserted, and the block must not be in linear mode. Linear mode follows the last write to a display-control register. When gated, a register write is still stored and reads back unchanged, but the bases stay where they were. Writing the control register with its linear bit clear recomputes both bases from the stored bytes. This re-applies the saved banking when the host leaves linear mode. Writing the control register with the linear bit set keeps the present bases.

Top module: `bank_mapper`

## Requirements
- R1: After reset, both bases are zero, both readback bytes are zero, and linear mode is off.
- R2: A write to the select byte (`bank_ext_sel`=0) takes effect when `unlock` is 1 and linear mode is off. From the next cycle, base bits 19:16 of the write base equal data bits 3:0, and those of the read base equal data bits 7:4. Bit 20 of each base is kept.
- R3: A write to the extension byte (`bank_ext_sel`=1) takes effect under the same conditions. Data bit 0 becomes write-base bit 20 and data bit 4 becomes read-base bit 20. Bits 19:16 of both bases are kept.
- R4: While `unlock` is 0, writes to either bank byte leave both bases unchanged.
- R5: While linear mode is on, writes to either bank byte leave both bases unchanged. The gate uses the mode held before the cycle, even when the control register is written in the same cycle.
- R6: Each readback output returns the last byte written to its register, whether or not that write changed a base.
- R7: A control write with `crtc_lin`=0 reloads both bases from the stored bytes on the next cycle, whatever `unlock` is. The stored bytes include any bank byte written in the same cycle. Write base = {ext[0], sel[3:0]}, read base = {ext[4], sel[7:4]}, both in 64 KiB units.
- R8: A control write with `crtc_lin`=1 turns linear mode on and keeps both bases as they were; they are not cleared.
- R9: Bits 15:0 of both bases are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bank_we | input | 1 | Strobe for a bank register byte write |
| bank_ext_sel | input | 1 | 0 selects the select byte, 1 the extension byte |
| bank_wdata | input | 8 | Byte written |
| unlock | input | 1 | Unlock key level |
| crtc_we | input | 1 | Strobe for a write to the display-control register |
| crtc_lin | input | 1 | Linear-mode bit of the byte written to the control register |
| wr_base | output | 21 | Base offset for host writes |
| rd_base | output | 21 | Base offset for host reads |
| sel_rdback | output | 8 | Stored select byte |
| ext_rdback | output | 8 | Stored extension byte |

## Verification
The bench targets these cases:
- A select write after an extension write. A design that overwrote the whole base would drop bit 20.
- Locked writes and writes made in linear mode. A design that ignored the gate would move the bases, and one that skipped storage would return stale readback.
- A linear-on control write after banking. A design that cleared the bases here would show zero.
- Leaving linear mode in the same cycle as a bank write. A design that reloaded from the old stored byte would show the earlier bank.
- Long random sequences, compared cycle by cycle against a model, to catch wrong ordering between gating and reload.

// File: rtl/bm_pkg.sv
package bm_pkg;

    typedef struct packed {
        logic [7:0] sel;
        logic [7:0] ext;
    } bm_regs_t;

    typedef struct packed {
        logic lin;
    } bm_mode_t;

endpackage

// File: rtl/bm_regs.sv
module bm_regs
    import bm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      we,
    input  logic      ext_sel,
    input  logic [7:0] wdata,
    output bm_regs_t  regs_d,
    output bm_regs_t  regs_q
);

    always_comb begin
        regs_d = regs_q;
        if (we) begin
            if (ext_sel) regs_d.ext = wdata;
            else         regs_d.sel = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    // R6
    store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> ($past(ext_sel) ? regs_q.ext : regs_q.sel) == $past(wdata));

endmodule

// File: rtl/bm_gate.sv
module bm_gate
    import bm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bank_we,
    input  logic bank_ext_sel,
    input  logic unlock,
    input  logic crtc_we,
    input  logic crtc_lin,
    output logic upd_sel,
    output logic upd_ext,
    output logic reload,
    output logic lin_mode
);

    bm_mode_t mode_d, mode_q;
    logic     open_d;

    always_comb begin
        mode_d  = mode_q;
        open_d  = bank_we && unlock && !mode_q.lin;
        upd_sel = open_d && !bank_ext_sel;
        upd_ext = open_d && bank_ext_sel;
        reload  = crtc_we && !crtc_lin;
        if (crtc_we) mode_d.lin = crtc_lin;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= '0;
        else        mode_q <= mode_d;
    end

    assign lin_mode = mode_q.lin;

    // R5
    lin_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lin_mode |-> !upd_sel && !upd_ext);

    // R8
    lin_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        crtc_we |=> lin_mode == $past(crtc_lin));

endmodule

// File: rtl/bm_base.sv
module bm_base
    import bm_pkg::*;
#(
    parameter int BASE_W    = 21,
    parameter int UNIT_LOG2 = 16,
    parameter int NIB_LO    = 0,
    parameter int EXT_BIT   = 0
)(
    input  logic              clk,
    input  logic              rst_n,
    input  bm_regs_t          regs_d,
    input  logic              upd_sel,
    input  logic              upd_ext,
    input  logic              reload,
    output logic [BASE_W-1:0] base
);

    localparam int HI_W  = BASE_W - UNIT_LOG2;
    localparam int NIB_W = HI_W - 1;

    logic [HI_W-1:0] hi_d, hi_q;

    always_comb begin
        hi_d = hi_q;
        if (reload) begin
            hi_d = {regs_d.ext[EXT_BIT], regs_d.sel[NIB_LO +: NIB_W]};
        end else begin
            if (upd_sel) hi_d[NIB_W-1:0] = regs_d.sel[NIB_LO +: NIB_W];
            if (upd_ext) hi_d[NIB_W]     = regs_d.ext[EXT_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hi_q <= '0;
        else        hi_q <= hi_d;
    end

    assign base = {hi_q, {UNIT_LOG2{1'b0}}};

    // R3
    ext_keeps_nib_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_ext && !upd_sel && !reload |=> $stable(hi_q[NIB_W-1:0]));

    // R2
    sel_keeps_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_sel && !upd_ext && !reload |=> $stable(hi_q[NIB_W]));

endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
    import bm_pkg::*;
#(
    parameter int BASE_W    = 21,
    parameter int UNIT_LOG2 = 16
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bank_we,
    input  logic              bank_ext_sel,
    input  logic [7:0]        bank_wdata,
    input  logic              unlock,
    input  logic              crtc_we,
    input  logic              crtc_lin,
    output logic [BASE_W-1:0] wr_base,
    output logic [BASE_W-1:0] rd_base,
    output logic [7:0]        sel_rdback,
    output logic [7:0]        ext_rdback
);

    localparam int NIB_W = BASE_W - UNIT_LOG2 - 1;

    bm_regs_t    regs_d, regs_q;
    logic        upd_sel, upd_ext, reload, lin_mode;
    logic [BASE_W-1:0] base_arr [2];

    bm_regs u_regs (
        .clk(clk), .rst_n(rst_n), .we(bank_we), .ext_sel(bank_ext_sel),
        .wdata(bank_wdata), .regs_d(regs_d), .regs_q(regs_q)
    );

    bm_gate u_gate (
        .clk(clk), .rst_n(rst_n), .bank_we(bank_we), .bank_ext_sel(bank_ext_sel),
        .unlock(unlock), .crtc_we(crtc_we), .crtc_lin(crtc_lin),
        .upd_sel(upd_sel), .upd_ext(upd_ext), .reload(reload), .lin_mode(lin_mode)
    );

    // direction 0 = write base (low nibble, ext bit 0); 1 = read base (high nibble, ext bit 4)
    for (genvar g = 0; g < 2; g++) begin : g_dir
        bm_base #(
            .BASE_W(BASE_W), .UNIT_LOG2(UNIT_LOG2),
            .NIB_LO(g * 4), .EXT_BIT(g * 4)
        ) u_base (
            .clk(clk), .rst_n(rst_n), .regs_d(regs_d),
            .upd_sel(upd_sel), .upd_ext(upd_ext), .reload(reload),
            .base(base_arr[g])
        );
    end

    assign wr_base    = base_arr[0];
    assign rd_base    = base_arr[1];
    assign sel_rdback = regs_q.sel;
    assign ext_rdback = regs_q.ext;

    // R2
    sel_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bank_we && !bank_ext_sel && unlock && !lin_mode && !crtc_we |=>
        wr_base[UNIT_LOG2 +: NIB_W] == $past(bank_wdata[NIB_W-1:0]) &&
        rd_base[UNIT_LOG2 +: NIB_W] == $past(bank_wdata[4 +: NIB_W]));

    // R4
    locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !unlock && !crtc_we |=> $stable(wr_base) && $stable(rd_base));

    // R5
    linear_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lin_mode && !crtc_we |=> $stable(wr_base) && $stable(rd_base));

    // R8
    lin_on_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        crtc_we && crtc_lin && (!bank_we || lin_mode || !unlock) |=>
        $stable(wr_base) && $stable(rd_base));

    // R7
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        crtc_we && !crtc_lin |=>
        wr_base[BASE_W-1:UNIT_LOG2] == {ext_rdback[0], sel_rdback[NIB_W-1:0]} &&
        rd_base[BASE_W-1:UNIT_LOG2] == {ext_rdback[4], sel_rdback[4 +: NIB_W]});

    // R6
    ext_rdback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bank_we && bank_ext_sel |=> ext_rdback == $past(bank_wdata));

endmodule

// File: tb/sim_bank_mapper.sv
module sim_bank_mapper;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bank_we = 1'b0, bank_ext_sel = 1'b0, unlock = 1'b0;
    logic        crtc_we = 1'b0, crtc_lin = 1'b0;
    logic [7:0]  bank_wdata = '0;
    logic [20:0] wr_base, rd_base;
    logic [7:0]  sel_rdback, ext_rdback;

    always #(CLK_PERIOD/2) clk = ~clk;

    bank_mapper u0 (
        .clk(clk), .rst_n(rst_n), .bank_we(bank_we), .bank_ext_sel(bank_ext_sel),
        .bank_wdata(bank_wdata), .unlock(unlock), .crtc_we(crtc_we), .crtc_lin(crtc_lin),
        .wr_base(wr_base), .rd_base(rd_base), .sel_rdback(sel_rdback), .ext_rdback(ext_rdback)
    );

    typedef struct {
        logic [20:0] wr;
        logic [20:0] rd;
        logic [7:0]  sel;
        logic [7:0]  ext;
        string       tag;
    } exp_t;

    exp_t q[$];
    int n_cmp = 0, n_bad = 0;
    bit done = 0;
    bit mon_on = 0;

    // reference model state
    logic [7:0] m_sel = 0, m_ext = 0;
    logic       m_lin = 0;
    logic [4:0] m_wr = 0, m_rd = 0;

    task automatic cmp(string tag, string what, logic [20:0] act, logic [20:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // driver: one operation per cycle, expected result pushed to the queue
    task automatic op(bit we, bit es, logic [7:0] d, bit ul, bit cw, bit cl, string tag);
        exp_t e;
        bit en;
        @(negedge clk);
        bank_we = we; bank_ext_sel = es; bank_wdata = d; unlock = ul;
        crtc_we = cw; crtc_lin = cl;
        en = we && ul && !m_lin;
        if (we) begin
            if (es) m_ext = d; else m_sel = d;
        end
        if (en) begin
            if (es) begin m_wr[4] = d[0]; m_rd[4] = d[4]; end
            else    begin m_wr[3:0] = d[3:0]; m_rd[3:0] = d[7:4]; end
        end
        if (cw) begin
            if (!cl) begin
                m_wr = {m_ext[0], m_sel[3:0]};
                m_rd = {m_ext[4], m_sel[7:4]};
            end
            m_lin = cl;
        end
        e.wr = {m_wr, 16'h0}; e.rd = {m_rd, 16'h0};
        e.sel = m_sel; e.ext = m_ext; e.tag = tag;
        q.push_back(e);
    endtask

    // monitor: results visible shortly after the edge that registers them
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (mon_on && q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                cmp(e.tag, "wr_base", wr_base, e.wr);
                cmp(e.tag, "rd_base", rd_base, e.rd);
                cmp(e.tag, "sel_rdback", {13'h0, sel_rdback}, {13'h0, e.sel});
                cmp(e.tag, "ext_rdback", {13'h0, ext_rdback}, {13'h0, e.ext});
                cmp("R9", "low bits", {5'h0, wr_base[15:0] | rd_base[15:0]}, 21'h0);
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R1: reset state
        cmp("R1", "wr_base", wr_base, 21'h0);
        cmp("R1", "rd_base", rd_base, 21'h0);
        cmp("R1", "sel_rdback", {13'h0, sel_rdback}, 21'h0);
        cmp("R1", "ext_rdback", {13'h0, ext_rdback}, 21'h0);
        @(negedge clk);
        rst_n = 1'b1;
        mon_on = 1;

        op(1, 0, 8'h5A, 1, 0, 0, "R2");          // select applied
        op(1, 1, 8'h11, 1, 0, 0, "R3");          // both top bits set, nibbles kept
        op(1, 0, 8'h3C, 1, 0, 0, "R2");          // top bit kept
        op(1, 1, 8'h10, 1, 0, 0, "R3");          // write top bit cleared only
        op(1, 0, 8'hF0, 0, 0, 0, "R4");          // locked: no effect, still stored
        op(1, 1, 8'h01, 0, 0, 0, "R4");
        op(0, 0, 8'h00, 1, 0, 0, "R6");          // readback holds locked bytes
        op(0, 0, 8'h00, 1, 1, 1, "R8");          // linear on, bases kept
        op(1, 0, 8'h77, 1, 0, 0, "R5");          // linear gates select
        op(1, 1, 8'h11, 1, 0, 0, "R5");
        op(0, 0, 8'h00, 0, 1, 0, "R7");          // leave linear while locked: reload
        op(1, 0, 8'h29, 1, 1, 1, "R5");          // same-cycle linear on: old mode opens
        op(1, 0, 8'h84, 1, 1, 0, "R7");          // same-cycle leave: gated write reloads
        op(0, 0, 8'h00, 1, 1, 1, "R8");
        op(0, 0, 8'h00, 1, 1, 1, "R8");          // repeated, still held

        for (int i = 0; i < 3000; i++) begin
            logic [7:0] r;
            r = 8'($urandom);
            op($urandom_range(0, 3) != 0, $urandom_range(0, 1), r,
               $urandom_range(0, 3) != 0, $urandom_range(0, 5) == 0,
               $urandom_range(0, 1), "R7 random");
        end
        op(0, 0, 8'h00, 1, 0, 0, "R6");
        repeat (3) @(posedge clk);
        #3;
        finish_run();
    end

endmodule